// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line Status

This block turns a serial input line into parallel characters. It uses a clock-enable pulse at sixteen times the bit rate. The start bit is recognised on a falling edge and checked again half a bit later. Each later bit is sampled at its centre. The word length, parity and stop-bit settings match those of the companion transmitter. A finished character goes into a one-deep receive buffer.

The block keeps five status flags next to the buffer: data-ready, overrun, parity error, framing error and break. The host uses two single-cycle strobes. One reads the buffer and clears data-ready. The other reads the status and clears the four error flags. The error flags are sticky: a later clean character does not clear them. If a character finishes while the buffer is still unread, the new character is dropped and the stored one is kept. The line settings are captured when a start bit is detected, so they stay fixed for the whole character.

Top module: `uart_rx_line`

## Requirements
- R1: A low level seen on a 16x tick starts a character. Eight ticks later the line is sampled again. If it is high, the start is discarded and no character is produced.
- R2: Data bits are sampled sixteen ticks apart, starting at the centre of the first data bit. The first bit received lands in bit 0 of the buffer. Word length is set by `cfg_wlen`: 00=5, 01=6, 10=7, 11=8 bits. Buffer bits above the word length read 0.
- R3: With `cfg_par_en`=1, one parity bit follows the data. Its expected value is the XOR of the data bits when `cfg_par_even`=1, and the inverse of that XOR when `cfg_par_even`=0. When `cfg_par_stick`=1, the expected value is instead the inverse of `cfg_par_even`. A mismatch sets `st_parity_err`.
- R4: Any checked stop bit sampled low sets `st_framing_err`. With `cfg_two_stop`=1 and a word length of 6 to 8, both stop bits are checked. With a 5-bit word, only the first stop bit is checked, so a 1.5-bit stop period is accepted.
- R5: When the data bits, the parity bit (if enabled) and every checked stop bit are all 0, the character is a break. It is stored as 0 and sets `st_break` and `st_framing_err`. No further character starts until the line has returned high.
- R6: Storing a character sets `st_data_ready`. A `rd_buf` pulse clears it, unless a character is stored in the same cycle.
- R7: If a character finishes while `st_data_ready`=1 and `rd_buf` is low, `st_overrun` is set. The new character is discarded, and the buffer and the other flags stay as they were.
- R8: The overrun, parity, framing and break flags stay set through later error-free characters. A `rd_status` pulse clears all four and leaves `st_data_ready` and the buffer unchanged.
- R9: After reset the buffer reads 0 and all five flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial input, idle high |
| cfg_wlen | input | 2 | Word length code (00=5 ... 11=8 bits) |
| cfg_two_stop | input | 1 | Two stop bits (1.5 for a 5-bit word) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_par_stick | input | 1 | Fixed parity bit equal to the inverse of cfg_par_even |
| rd_buf | input | 1 | Host read strobe for the receive buffer |
| rd_status | input | 1 | Host read strobe for the status flags |
| rbr_data | output | 8 | Receive buffer contents |
| st_data_ready | output | 1 | Buffer holds an unread character |
| st_overrun | output | 1 | A character was lost to a full buffer |
| st_parity_err | output | 1 | A parity mismatch occurred |
| st_framing_err | output | 1 | A stop bit was sampled low |
| st_break | output | 1 | An all-zero character was received |

## Verification
A wrong bit counter or tick counter shows up in the same character. The buffer then holds a shifted value, or a stop-bit sample lands on a data bit and raises a false framing error. Both are visible one clock after the stop-bit sample. A flag that fails to stick, or a status read that clears too much, is only visible once the next clean character has arrived or the read strobe has fired. For that reason the flags are checked around such events, not only right after the faulty character. A receiver stuck after a break or a false start is caught by the next good character, which then fails to appear in the buffer.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int DATA_W = 8;
    localparam int MIN_BITS = 5;

    typedef struct packed {
        logic [1:0] wlen;
        logic       two_stop;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } line_cfg_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP1,
        RX_STOP2,
        RX_MARK
    } rx_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              frm_err;
        logic              brk;
    } rx_char_t;

    function automatic logic [3:0] word_bits(input logic [1:0] wlen);
        return 4'(MIN_BITS) + {2'b00, wlen};
    endfunction

    function automatic logic expected_parity(input logic [DATA_W-1:0] d,
                                             input line_cfg_t c);
        logic ones;
        ones = ^d;
        if (c.par_stick)
            return ~c.par_even;
        return c.par_even ? ones : ~ones;
    endfunction

    function automatic logic needs_second_stop(input line_cfg_t c);
        return c.two_stop && (c.wlen != 2'b00);
    endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rx,
    input  line_cfg_t cfg,
    output logic      done,
    output rx_char_t  chr
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    rx_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] shreg;
    line_cfg_t         cfg_q;
    logic              par_q;
    logic              stop1_q;

    logic              at_mid, at_last, last_bit;
    logic              stop_first, stops_high, stops_low;
    logic              par_bad, all_zero;

    always_comb begin
        at_mid     = (cnt == MID);
        at_last    = (cnt == LAST);
        last_bit   = ({1'b0, idx} == 4'(word_bits(cfg_q.wlen) - 4'd1));
        stop_first = (state == RX_STOP2) ? stop1_q : rx;
        stops_high = stop_first & rx;
        stops_low  = ~stop_first & ~rx;
        par_bad    = cfg_q.par_en && (par_q != expected_parity(shreg, cfg_q));
        all_zero   = (shreg == '0) && (!cfg_q.par_en || !par_q) && stops_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shreg   <= '0;
            cfg_q   <= '0;
            par_q   <= 1'b0;
            stop1_q <= 1'b1;
            done    <= 1'b0;
            chr     <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx) begin
                            state <= RX_START;
                            cnt   <= '0;
                            cfg_q <= cfg;
                            shreg <= '0;
                            par_q <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (at_mid) begin
                            cnt <= '0;
                            idx <= '0;
                            state <= rx ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (at_last) begin
                            cnt        <= '0;
                            shreg[idx] <= rx;
                            if (last_bit)
                                state <= cfg_q.par_en ? RX_PARITY : RX_STOP1;
                            else
                                idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_PARITY: begin
                        if (at_last) begin
                            cnt   <= '0;
                            par_q <= rx;
                            state <= RX_STOP1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP1, RX_STOP2: begin
                        if (at_last) begin
                            cnt <= '0;
                            if (state == RX_STOP1 && needs_second_stop(cfg_q)) begin
                                stop1_q <= rx;
                                state   <= RX_STOP2;
                            end else begin
                                done         <= 1'b1;
                                chr.data     <= shreg;
                                chr.par_err  <= par_bad;
                                chr.frm_err  <= ~stops_high;
                                chr.brk      <= all_zero;
                                state        <= rx ? RX_IDLE : RX_MARK;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_MARK: begin
                        if (rx) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    // R1: a finished character is reported for exactly one cycle
    a_r1_single_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: a break always carries a framing error
    a_r5_break_framing: assert property (@(posedge clk) disable iff (rst)
        (done && chr.brk) |-> chr.frm_err);

    // R2: bits above a 5-bit word stay clear
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (done && cfg_q.wlen == 2'b00) |-> (chr.data[DATA_W-1:MIN_BITS] == '0));

    // R5: after a break the receiver waits for a high line
    a_r5_mark_wait: assert property (@(posedge clk) disable iff (rst)
        (state == RX_MARK && !rx) |=> (state == RX_MARK));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  rx_char_t          chr,
    input  logic              rd_buf,
    input  logic              rd_status,
    output logic [DATA_W-1:0] buf_q,
    output logic              dr_q,
    output logic              oe_q,
    output logic              pe_q,
    output logic              fe_q,
    output logic              bi_q
);
    logic load, lost;
    logic dr_n, oe_n, pe_n, fe_n, bi_n;

    always_comb begin
        load = done && (!dr_q || rd_buf);
        lost = done && dr_q && !rd_buf;
        dr_n = load ? 1'b1 : (rd_buf ? 1'b0 : dr_q);
        oe_n = (rd_status ? 1'b0 : oe_q) | lost;
        pe_n = (rd_status ? 1'b0 : pe_q) | (load & chr.par_err);
        fe_n = (rd_status ? 1'b0 : fe_q) | (load & chr.frm_err);
        bi_n = (rd_status ? 1'b0 : bi_q) | (load & chr.brk);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            dr_q  <= 1'b0;
            oe_q  <= 1'b0;
            pe_q  <= 1'b0;
            fe_q  <= 1'b0;
            bi_q  <= 1'b0;
        end else begin
            if (load) buf_q <= chr.data;
            dr_q <= dr_n;
            oe_q <= oe_n;
            pe_q <= pe_n;
            fe_q <= fe_n;
            bi_q <= bi_n;
        end
    end

    a_r6_ready_on_load: assert property (@(posedge clk) disable iff (rst)
        (done && !dr_q) |=> dr_q);

    a_r6_read_clears_ready: assert property (@(posedge clk) disable iff (rst)
        (rd_buf && !done) |=> !dr_q);

    a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
        (done && dr_q && !rd_buf) |=> (oe_q && $stable(buf_q)));

    a_r8_status_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_status && !done) |=> !(oe_q | pe_q | fe_q | bi_q));

    a_r8_parity_sticky: assert property (@(posedge clk) disable iff (rst)
        (pe_q && !rd_status) |=> pe_q);

    a_r8_framing_sticky: assert property (@(posedge clk) disable iff (rst)
        (fe_q && !rd_status) |=> fe_q);
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16x,
    input  logic              rxd,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_two_stop,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              rd_buf,
    input  logic              rd_status,
    output logic [DATA_W-1:0] rbr_data,
    output logic              st_data_ready,
    output logic              st_overrun,
    output logic              st_parity_err,
    output logic              st_framing_err,
    output logic              st_break
);
    line_cfg_t cfg;
    logic      rx_s;
    logic      char_done;
    rx_char_t  char_q;

    always_comb begin
        cfg.wlen      = cfg_wlen;
        cfg.two_stop  = cfg_two_stop;
        cfg.par_en    = cfg_par_en;
        cfg.par_even  = cfg_par_even;
        cfg.par_stick = cfg_par_stick;
    end

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_frame #(.OSR(OSR)) u_frame (
        .clk  (clk),
        .rst  (rst),
        .tick (tick_16x),
        .rx   (rx_s),
        .cfg  (cfg),
        .done (char_done),
        .chr  (char_q)
    );

    uart_rx_status u_status (
        .clk       (clk),
        .rst       (rst),
        .done      (char_done),
        .chr       (char_q),
        .rd_buf    (rd_buf),
        .rd_status (rd_status),
        .buf_q     (rbr_data),
        .dr_q      (st_data_ready),
        .oe_q      (st_overrun),
        .pe_q      (st_parity_err),
        .fe_q      (st_framing_err),
        .bi_q      (st_break)
    );

    // R9: nothing is flagged before the first character
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(st_data_ready | st_overrun | st_parity_err | st_framing_err | st_break));
endmodule

// File: tb/uart_rx_line_bench.sv
module uart_rx_line_bench;
    localparam int TICK_DIV = 4;
    localparam int HALF_CLK = 8 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_status = 1'b0;
    logic [7:0] rbr_data;
    logic       st_data_ready, st_overrun, st_parity_err, st_framing_err, st_break;

    int checks = 0;
    int errors = 0;
    int tick_cnt = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
        tick_16x <= (tick_cnt == 0);
    end

    uart_rx_line u_uart_rx_line (
        .clk(clk), .rst(rst), .tick_16x(tick_16x), .rxd(rxd),
        .cfg_wlen(cfg_wlen), .cfg_two_stop(cfg_two_stop), .cfg_par_en(cfg_par_en),
        .cfg_par_even(cfg_par_even), .cfg_par_stick(cfg_par_stick),
        .rd_buf(rd_buf), .rd_status(rd_status), .rbr_data(rbr_data),
        .st_data_ready(st_data_ready), .st_overrun(st_overrun),
        .st_parity_err(st_parity_err), .st_framing_err(st_framing_err),
        .st_break(st_break)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input int halves);
        @(negedge clk) rxd = v;
        repeat (halves * HALF_CLK - 1) @(negedge clk);
    endtask

    function automatic logic ref_par(input logic [7:0] d, input int n,
                                     input logic even, input logic stick);
        logic x;
        x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        if (stick) return ~even;
        return even ? x : ~x;
    endfunction

    // stop_halves: length of the stop period in half bits; bad_stop2 sends low second stop
    task automatic send_char(input logic [7:0] d, input int n, input logic pen,
                             input logic pbit, input int stop_halves, input logic bad_stop2);
        drive(1'b0, 2);
        for (int i = 0; i < n; i++) drive(d[i], 2);
        if (pen) drive(pbit, 2);
        if (bad_stop2) begin
            drive(1'b1, 2);
            drive(1'b0, 2);
        end else begin
            drive(1'b1, stop_halves);
        end
        drive(1'b1, 4);
    endtask

    task automatic pulse_rd_buf();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
    endtask

    task automatic pulse_rd_status();
        @(negedge clk) rd_status = 1'b1;
        @(negedge clk) rd_status = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] w, input logic ts, input logic pe,
                           input logic ev, input logic st);
        @(negedge clk);
        cfg_wlen = w; cfg_two_stop = ts; cfg_par_en = pe; cfg_par_even = ev; cfg_par_stick = st;
    endtask

    task automatic t_reset();
        chk("R9 buffer", rbr_data, 8'h00);
        chk("R9 flags", {st_data_ready, st_overrun, st_parity_err, st_framing_err, st_break}, 5'b0);
    endtask

    task automatic t_basic();
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send_char(8'hA5, 8, 1'b0, 1'b0, 2, 1'b0);
        chk("R2 8-bit data", rbr_data, 8'hA5);
        chk("R6 ready set", st_data_ready, 1'b1);
        chk("R4 no framing", st_framing_err, 1'b0);
        pulse_rd_buf();
        chk("R6 ready cleared", st_data_ready, 1'b0);
        chk("R6 buffer kept", rbr_data, 8'hA5);
    endtask

    task automatic t_wlen();
        set_cfg(2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        send_char(8'hF6, 5, 1'b0, 1'b0, 2, 1'b0);
        chk("R2 5-bit data", rbr_data, 8'h16);
        pulse_rd_buf();
        set_cfg(2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
        send_char(8'h4B, 7, 1'b0, 1'b0, 2, 1'b0);
        chk("R2 7-bit data", rbr_data, 8'h4B);
        pulse_rd_buf();
    endtask

    task automatic t_parity();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        send_char(8'h37, 8, 1'b1, ref_par(8'h37, 8, 1'b1, 1'b0), 2, 1'b0);
        chk("R3 even good", st_parity_err, 1'b0);
        chk("R3 even data", rbr_data, 8'h37);
        pulse_rd_buf();
        send_char(8'h37, 8, 1'b1, ~ref_par(8'h37, 8, 1'b1, 1'b0), 2, 1'b0);
        chk("R3 even bad", st_parity_err, 1'b1);
        pulse_rd_buf();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        send_char(8'h37, 8, 1'b1, ref_par(8'h37, 8, 1'b0, 1'b0), 2, 1'b0);
        chk("R8 parity sticky", st_parity_err, 1'b1);
        pulse_rd_status();
        chk("R8 parity cleared", st_parity_err, 1'b0);
        chk("R8 ready untouched", st_data_ready, 1'b1);
        pulse_rd_buf();
        send_char(8'h37, 8, 1'b1, ~ref_par(8'h37, 8, 1'b0, 1'b0), 2, 1'b0);
        chk("R3 odd bad", st_parity_err, 1'b1);
        pulse_rd_buf();
        pulse_rd_status();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b1);
        send_char(8'hFF, 8, 1'b1, 1'b0, 2, 1'b0);
        chk("R3 stick good", st_parity_err, 1'b0);
        pulse_rd_buf();
        send_char(8'hFF, 8, 1'b1, 1'b1, 2, 1'b0);
        chk("R3 stick bad", st_parity_err, 1'b1);
        pulse_rd_buf();
        pulse_rd_status();
    endtask

    task automatic t_stop();
        set_cfg(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        send_char(8'h5A, 8, 1'b0, 1'b0, 4, 1'b0);
        chk("R4 two stops good", st_framing_err, 1'b0);
        pulse_rd_buf();
        send_char(8'h5A, 8, 1'b0, 1'b0, 4, 1'b1);
        chk("R4 second stop low", st_framing_err, 1'b1);
        chk("R4 data kept", rbr_data, 8'h5A);
        pulse_rd_buf();
        pulse_rd_status();
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 2);
        for (int i = 0; i < 5; i++) drive(logic'((5'h0B >> i) & 1), 2);
        drive(1'b1, 3);
        drive(1'b0, 2);
        for (int i = 0; i < 5; i++) drive(logic'((5'h13 >> i) & 1), 2);
        drive(1'b1, 3);
        chk("R4 1.5 stop no framing", st_framing_err, 1'b0);
        chk("R7 back-to-back overrun", st_overrun, 1'b1);
        chk("R4 1.5 stop data", rbr_data, 8'h0B);
        pulse_rd_buf();
        pulse_rd_status();
    endtask

    task automatic t_false_start();
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 1);
        drive(1'b1, 6);
        chk("R1 false start dropped", st_data_ready, 1'b0);
        send_char(8'h3C, 8, 1'b0, 1'b0, 2, 1'b0);
        chk("R1 next char ok", rbr_data, 8'h3C);
        pulse_rd_buf();
    endtask

    task automatic t_break();
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 30);
        chk("R5 break flag", st_break, 1'b1);
        chk("R5 break framing", st_framing_err, 1'b1);
        chk("R5 break data", rbr_data, 8'h00);
        chk("R5 break ready", st_data_ready, 1'b1);
        pulse_rd_buf();
        drive(1'b1, 6);
        chk("R5 single char", st_data_ready, 1'b0);
        pulse_rd_status();
        chk("R8 break cleared", st_break, 1'b0);
    endtask

    task automatic t_overrun();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        send_char(8'h81, 8, 1'b1, ref_par(8'h81, 8, 1'b1, 1'b0), 2, 1'b0);
        send_char(8'h7E, 8, 1'b1, ~ref_par(8'h7E, 8, 1'b1, 1'b0), 2, 1'b0);
        chk("R7 overrun set", st_overrun, 1'b1);
        chk("R7 old char kept", rbr_data, 8'h81);
        chk("R7 lost char no parity", st_parity_err, 1'b0);
        pulse_rd_status();
        chk("R8 overrun cleared", st_overrun, 1'b0);
        pulse_rd_buf();
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_wlen();
        t_parity();
        t_stop();
        t_false_start();
        t_break();
        t_overrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule